// File: doc/BRIEF.md
# Fine-Grained Warp Issue Scheduler

This block keeps the issue context of a fixed set of resident warps: one program counter per warp and a ready or stalled flag. Every cycle it picks one ready warp and presents its index and PC to a shared SIMD execution unit. The issue decision is made once per warp, so a single issue serves all of that warp's threads. Contexts are never saved or restored. They stay in place, and changing to another warp costs no cycles beyond the normal selection.

When the execution side reports that a warp has hit a long-latency event, such as a memory load, the block flags that warp as stalled. From the next cycle it issues from the other ready warps. A stalled warp stays out of selection for as long as the event lasts, which may be hundreds of cycles. It becomes eligible again only when a completion event names it. This design favours overall issue throughput over the latency of any one warp.

The issue outputs depend only on registered state. A stall reported for the warp issuing in the same cycle cancels that issue's PC step, so the instruction is re-issued once the warp is ready again.

Top module: `warp_sched`

## Requirements
- R1: While reset is low, and in the first cycle after release, every warp is ready, warp w holds PC `BASE_PC + w*PC_STRIDE`, and the block issues warp 0 with `issueValid` high.
- R2: Ready warps are issued round-robin. The search starts at the warp index after the last issued one and wraps from `NUM_WARPS-1` to 0.
- R3: When a warp is issued and its `stallMask` bit is low in that cycle, its PC is one higher in the next cycle.
- R4: When a warp is issued and its `stallMask` bit (bit w stands for warp w) is high in the same cycle, its PC is held. It is not issued in the next cycle, and another ready warp is issued instead.
- R5: A stalled warp is never issued, however many cycles pass, until a completion event names it.
- R6: A completion event (`doneValid` high, `doneWarp` = binary warp index) makes a stalled warp ready from the next cycle. It then resumes at its held PC.
- R7: When a completion event and a `stallMask` bit name the same warp in the same cycle, the warp ends up stalled.
- R8: In a cycle where no warp is ready, `issueValid` is low.
- R9: The PC of a warp that is not issued in a cycle does not change. A `stallMask` bit also stalls a warp that is not issuing.
- R10: A completion event for a warp that is already ready has no effect on the issue order or on any PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| stallMask | input | NUM_WARPS | Bit w high: warp w enters the stalled state |
| doneValid | input | 1 | A completion event is present this cycle |
| doneWarp | input | $clog2(NUM_WARPS) | Warp index of the completion event |
| issueValid | output | 1 | A warp is issued this cycle |
| issueWarp | output | $clog2(NUM_WARPS) | Index of the issued warp |
| issuePc | output | PC_W | PC of the issued warp |

## Verification
The two functions that can meet in one cycle are the return of a warp to ready and its entry into the stalled state. A second pairing is a stall landing on the warp that is issuing at that moment. The stimulus table drives a completion and a stall for the same warp together, and also raises a stall on the current issue slot. The bench then judges the outcome at the ports over the following cycles. A correct result shows that warp absent from issue until a later, lone completion, and a repeated issue at the unchanged PC. The bound checker states both properties cycle by cycle.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  // Upper bound on the warp index width carried in the strobe struct
  localparam int WID_MAX = 8;

  // Strobes from control to the context datapath
  typedef struct packed {
    logic               advance;  // step the PC of the selected warp
    logic [WID_MAX-1:0] warp;     // selected warp index, zero-extended
  } ctxStrobe_t;
endpackage

// File: rtl/warp_sched_ctrl.sv
module warp_sched_ctrl
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int WID_W     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WARPS-1:0] stallMask,
  input  logic                 doneValid,
  input  logic [WID_W-1:0]     doneWarp,
  output logic                 issueValid,
  output logic [WID_W-1:0]     issueWarp,
  output ctxStrobe_t           strobe
);

  logic [NUM_WARPS-1:0] readyQ;
  logic [NUM_WARPS-1:0] doneHot;
  logic [WID_W-1:0]     lastQ;
  logic [WID_W-1:0]     pick;
  logic                 found;

  always_comb begin
    doneHot = '0;
    if (doneValid) doneHot[doneWarp] = 1'b1;
  end

  // Round-robin search starting after the last issued warp
  always_comb begin
    found = 1'b0;
    pick  = lastQ;
    for (int i = 1; i <= NUM_WARPS; i++) begin
      int k;
      k = int'(lastQ) + i;
      if (k >= NUM_WARPS) k = k - NUM_WARPS;
      if (!found && readyQ[WID_W'(k)]) begin
        found = 1'b1;
        pick  = WID_W'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= '1;
      lastQ  <= WID_W'(NUM_WARPS - 1);
    end else begin
      // a stall wins over a completion for the same warp
      readyQ <= (readyQ | doneHot) & ~stallMask;
      if (found) lastQ <= pick;
    end
  end

  assign issueValid     = found;
  assign issueWarp      = pick;
  assign strobe.advance = found && !stallMask[pick];
  assign strobe.warp    = WID_MAX'(pick);

endmodule

// File: rtl/warp_sched_ctx.sv
module warp_sched_ctx
  import warp_sched_pkg::*;
#(
  parameter int          NUM_WARPS = 4,
  parameter int          WID_W     = 2,
  parameter int          PC_W      = 16,
  parameter int unsigned BASE_PC   = 32'h100,
  parameter int unsigned PC_STRIDE = 32'h40
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctxStrobe_t                      strobe,
  output logic [PC_W-1:0]                 readPc,
  output logic [NUM_WARPS-1:0][PC_W-1:0]  pcAll
);

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_ctx
    logic [PC_W-1:0] pcQ;
    always_ff @(posedge clk) begin
      if (!rstN)
        pcQ <= PC_W'(BASE_PC + w * PC_STRIDE);
      else if (strobe.advance && strobe.warp == WID_MAX'(w))
        pcQ <= pcQ + PC_W'(1);
    end
    assign pcAll[w] = pcQ;
  end

  assign readPc = pcAll[strobe.warp[WID_W-1:0]];

endmodule

// File: rtl/warp_sched.sv
module warp_sched
  import warp_sched_pkg::*;
#(
  parameter int          NUM_WARPS = 4,
  parameter int          PC_W      = 16,
  parameter int unsigned BASE_PC   = 32'h100,
  parameter int unsigned PC_STRIDE = 32'h40,
  localparam int         WID_W     = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WARPS-1:0] stallMask,
  input  logic                 doneValid,
  input  logic [WID_W-1:0]     doneWarp,
  output logic                 issueValid,
  output logic [WID_W-1:0]     issueWarp,
  output logic [PC_W-1:0]      issuePc
);

  ctxStrobe_t                     strobe;
  logic [NUM_WARPS-1:0][PC_W-1:0] pcAll;

  warp_sched_ctrl #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .stallMask(stallMask), .doneValid(doneValid),
    .doneWarp(doneWarp), .issueValid(issueValid), .issueWarp(issueWarp),
    .strobe(strobe)
  );

  warp_sched_ctx #(
    .NUM_WARPS(NUM_WARPS), .WID_W(WID_W), .PC_W(PC_W),
    .BASE_PC(BASE_PC), .PC_STRIDE(PC_STRIDE)
  ) ctx_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .readPc(issuePc), .pcAll(pcAll)
  );

endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk #(
  parameter int  NUM_WARPS = 4,
  parameter int  PC_W      = 16,
  localparam int WID_W     = $clog2(NUM_WARPS)
) (
  input logic                           clk,
  input logic                           rstN,
  input logic [NUM_WARPS-1:0]           stallMask,
  input logic                           doneValid,
  input logic [WID_W-1:0]               doneWarp,
  input logic                           issueValid,
  input logic [WID_W-1:0]               issueWarp,
  input logic [PC_W-1:0]                issuePc,
  input logic [NUM_WARPS-1:0][PC_W-1:0] pcAll
);

  // R3: an unstalled issue steps that warp's PC by one
  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !stallMask[issueWarp] |=>
      pcAll[$past(issueWarp)] == $past(issuePc) + PC_W'(1));

  // R4: a warp stalled while issuing is not issued in the next cycle
  p_stall_switch_r4: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && stallMask[issueWarp] |=>
      !(issueValid && issueWarp == $past(issueWarp)));

  // R7: completion and stall in one cycle leave the warp stalled
  p_conflict_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && stallMask[doneWarp] |=>
      !(issueValid && issueWarp == $past(doneWarp)));

  // R8: all warps stalled with no completion -> no issue next cycle
  p_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (&stallMask) && !doneValid |=> !issueValid);

  // R9: a warp that is not issued keeps its PC
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_hold
    p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      !(issueValid && issueWarp == WID_W'(w)) |=>
        pcAll[w] == $past(pcAll[w]));
  end

endmodule

bind warp_sched warp_sched_chk #(.NUM_WARPS(NUM_WARPS), .PC_W(PC_W)) chk_i (.*);

// File: tb/warp_sched_tb_top.sv
module warp_sched_tb_top;

  localparam int NW = 4;
  localparam int PW = 16;

  typedef struct packed {
    logic [3:0]  stall;
    logic        dv;
    logic [1:0]  dw;
    logic        ev;
    logic [1:0]  ew;
    logic [15:0] epc;
    logic [3:0]  req;
  } vec_t;

  // warp w starts at 0x100 + w*0x40; expectations are the outputs seen in that cycle
  localparam vec_t VECS [20] = '{
    '{4'b0000, 1'b0, 2'd0, 1'b1, 2'd0, 16'h0100, 4'd1},  // R1 first issue
    '{4'b0000, 1'b0, 2'd0, 1'b1, 2'd1, 16'h0140, 4'd2},  // R2
    '{4'b0100, 1'b0, 2'd0, 1'b1, 2'd2, 16'h0180, 4'd4},  // R4 stall on issuing warp
    '{4'b0000, 1'b0, 2'd0, 1'b1, 2'd3, 16'h01C0, 4'd2},
    '{4'b0000, 1'b0, 2'd0, 1'b1, 2'd0, 16'h0101, 4'd3},  // R3
    '{4'b0000, 1'b0, 2'd0, 1'b1, 2'd1, 16'h0141, 4'd3},
    '{4'b0000, 1'b0, 2'd0, 1'b1, 2'd3, 16'h01C1, 4'd5},  // R5 skip stalled
    '{4'b0000, 1'b1, 2'd2, 1'b1, 2'd0, 16'h0102, 4'd2},
    '{4'b0000, 1'b0, 2'd0, 1'b1, 2'd1, 16'h0142, 4'd2},
    '{4'b0000, 1'b0, 2'd0, 1'b1, 2'd2, 16'h0180, 4'd6},  // R6 held PC
    '{4'b1011, 1'b0, 2'd0, 1'b1, 2'd3, 16'h01C2, 4'd9},  // R9 stall non-issuing
    '{4'b0100, 1'b0, 2'd0, 1'b1, 2'd2, 16'h0181, 4'd4},
    '{4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 4'd8},  // R8 none ready
    '{4'b0010, 1'b1, 2'd1, 1'b0, 2'd0, 16'h0000, 4'd8},  // R7 conflict
    '{4'b0000, 1'b1, 2'd3, 1'b0, 2'd0, 16'h0000, 4'd7},  // R7 w1 still out
    '{4'b0000, 1'b0, 2'd0, 1'b1, 2'd3, 16'h01C2, 4'd6},
    '{4'b0000, 1'b1, 2'd0, 1'b1, 2'd3, 16'h01C3, 4'd2},
    '{4'b0000, 1'b0, 2'd0, 1'b1, 2'd0, 16'h0103, 4'd2},
    '{4'b0000, 1'b1, 2'd3, 1'b1, 2'd3, 16'h01C4, 4'd10}, // R10 done on ready warp
    '{4'b0000, 1'b0, 2'd0, 1'b1, 2'd0, 16'h0104, 4'd10}
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic [NW-1:0] stallMask;
  logic          doneValid;
  logic [1:0]    doneWarp;
  logic          issueValid;
  logic [1:0]    issueWarp;
  logic [PW-1:0] issuePc;

  int nChecks = 0;
  int nFails  = 0;

  always #4ns clk = ~clk;

  warp_sched #(.NUM_WARPS(NW), .PC_W(PW)) dut_i (
    .clk(clk), .rstN(rstN), .stallMask(stallMask), .doneValid(doneValid),
    .doneWarp(doneWarp), .issueValid(issueValid), .issueWarp(issueWarp),
    .issuePc(issuePc)
  );

  task automatic checkOut(string req, logic ev, logic [1:0] ew, logic [15:0] epc);
    logic ok;
    nChecks++;
    ok = ev ? (issueValid === 1'b1 && issueWarp === ew && issuePc === epc)
            : (issueValid === 1'b0);
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got valid=%b warp=%0d pc=%h, expected valid=%b warp=%0d pc=%h",
               req, issueValid, issueWarp, issuePc, ev, ew, epc);
    end
  endtask

  initial begin
    #(8ns * 200000);
    nFails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic sawW1;
    rstN = 1'b0; stallMask = '0; doneValid = 1'b0; doneWarp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkOut("R1 reset", 1'b1, 2'd0, 16'h0100);
    rstN = 1'b1;

    // table walk
    for (int i = 0; i < 20; i++) begin
      stallMask = VECS[i].stall;
      doneValid = VECS[i].dv;
      doneWarp  = VECS[i].dw;
      checkOut($sformatf("R%0d row %0d", VECS[i].req, i), VECS[i].ev, VECS[i].ew, VECS[i].epc);
      @(negedge clk);
    end
    stallMask = '0; doneValid = 1'b0;

    // R1: reset in mid-run restores the initial contexts
    rstN = 1'b0;
    @(negedge clk);
    checkOut("R1 mid-run reset", 1'b1, 2'd0, 16'h0100);
    rstN = 1'b1;

    // R2: full rotation over two rounds
    for (int i = 0; i < 8; i++) begin
      checkOut("R2 rotation", 1'b1, 2'(i % 4), 16'(16'h0100 + (i % 4) * 16'h40 + i / 4));
      @(negedge clk);
    end

    // R5: stall warp 1 while warp 0 issues, then hold it out for 300 cycles
    stallMask = 4'b0010;
    checkOut("R9 issue during foreign stall", 1'b1, 2'd0, 16'h0102);
    @(negedge clk);
    stallMask = '0;
    sawW1 = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (issueValid && issueWarp == 2'd1) sawW1 = 1'b1;
      @(negedge clk);
    end
    nChecks++;
    if (sawW1) begin
      nFails++;
      $display("FAIL R5: got warp 1 issued while stalled, expected never");
    end

    // R6: release warp 1 while stalling the rest; only warp 1 can issue
    stallMask = 4'b1101; doneValid = 1'b1; doneWarp = 2'd1;
    @(negedge clk);
    stallMask = '0; doneValid = 1'b0;
    checkOut("R6 resume", 1'b1, 2'd1, 16'h0142);
    @(negedge clk);
    checkOut("R8 others stalled", 1'b1, 2'd1, 16'h0143);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule